// File: doc/BRIEF.md
# MIDI UART Port with Command Handshake

This block gives a host an 8-bit, two-address window onto a serial MIDI line. Address 0 is the data register and address 1 is the command register on writes and the status register on reads. After power-up the port is in a command-only mode. It understands two command bytes. One switches the port into pass-through UART operation. The other returns it to the command-only mode. Each accepted command is confirmed by an acknowledge byte that the host reads back from the data register.

In UART mode, host data bytes go into a one-byte holding register. From there they pass to a serializer that sends 8 data bits, no parity and one stop bit at 31250 baud. The clock divider is derived from a parameter. Bytes from the deserializer go into a one-byte receive register. The two readiness flags are active-low. A sticky overrun flag records receive bytes that were lost. Two interrupt request outputs report that the transmit holding register is empty and that received data is waiting. Each request has its own enable input.

Top module: `midi_port`

## Requirements
- R1: After reset the status register reads 0x80, both interrupt outputs are 0, the serial output idles at 1, and the port is in command-only mode.
- R2: Writing 0x3F to the command address while in command-only mode enters UART mode and loads the acknowledge byte 0xFE into the data register, so status bit 7 reads 0.
- R3: A data register read returns the waiting byte and sets status bit 7 back to 1. A status read has no side effect.
- R4: Writing 0x3F while already in UART mode produces no acknowledge and leaves the port in UART mode.
- R5: Any command byte other than 0xFF and 0x3F is ignored. It produces no acknowledge and no change of mode.
- R6: Status bit 6 reads 0 when the transmit holding register is empty. A data write made while bit 6 reads 1 is dropped. The serializer and the holding register can have two bytes outstanding between them.
- R7: Each transmitted byte is sent as one start bit of 0, then 8 data bits with the LSB first, then one stop bit of 1. Each bit lasts CLK_HZ/BAUD clocks, and the line idles high.
- R8: irq_tx equals tx_irq_en AND UART mode AND holding register empty. irq_rx equals rx_irq_en AND status bit 7 low. A cleared enable holds its request at 0.
- R9: In UART mode, a correctly framed serial byte is loaded into the data register and status bit 7 reads 0.
- R10: A serial byte that arrives while the data register is still full is dropped and sets status bit 0. Bit 0 stays set across reads until a 0xFF command.
- R11: In command-only mode, data writes are ignored and received serial bytes are discarded.
- R12: Writing 0xFF in either mode flushes the holding register, clears the overrun flag, returns to command-only mode and loads the acknowledge byte 0xFE. A frame already on the line completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register access select |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| a0 | input | 1 | 0 = data register, 1 = command/status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after rd |
| tx_irq_en | input | 1 | Transmit-empty request enable |
| rx_irq_en | input | 1 | Receive-ready request enable |
| irq_tx | output | 1 | Transmit holding register empty request |
| irq_rx | output | 1 | Received byte or acknowledge waiting request |
| midi_rx | input | 1 | Serial MIDI input |
| midi_tx | output | 1 | Serial MIDI output |

## Verification
A wrong mode bit shows up within one clock on irq_tx, because irq_tx is gated by UART mode. It also shows at the first command write as a missing or extra acknowledge. A corrupted receive-full flag appears on irq_rx in the same clock. The bench compares irq_rx on every clock against its own model. A lost or extra holding byte shows up only at frame granularity, as a missing frame, or as a frame appearing in a window that must stay idle, roughly ten bit times later.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;
  localparam int ST_RX_N = 7;
  localparam int ST_TX_N = 6;
  localparam int ST_OVR  = 0;
endpackage

// File: rtl/midi_tx_ser.sv
module midi_tx_ser #(
  parameter int DIV = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       line
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] divc;
  logic [3:0]    bitc;
  logic [8:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      line <= 1'b1;
      divc <= '0;
      bitc <= '0;
      sh   <= '1;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        line <= 1'b0;
        sh   <= {1'b1, data};
        bitc <= 4'd9;
        divc <= CW'(DIV - 1);
      end
    end else if (divc == '0) begin
      divc <= CW'(DIV - 1);
      if (bitc == 4'd0) begin
        busy <= 1'b0;
      end else begin
        line <= sh[0];
        sh   <= {1'b1, sh[8:1]};
        bitc <= bitc - 4'd1;
      end
    end else begin
      divc <= divc - CW'(1);
    end
  end

  // R7: idle line is high
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst) !busy |-> line);
  // R6: the holding register only hands over a byte to an idle serializer
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
endmodule

// File: rtl/midi_rx_deser.sv
module midi_rx_deser #(
  parameter int DIV = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  output logic       valid,
  output logic [7:0] data
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic          s1, s2, active;
  logic [CW-1:0] cnt;
  logic [3:0]    bitc;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      active <= 1'b0;
      cnt <= '0;
      bitc <= '0;
      sh <= '0;
      valid <= 1'b0;
      data <= '0;
    end else begin
      s1 <= line;
      s2 <= s1;
      valid <= 1'b0;
      if (!active) begin
        if (!s2) begin
          active <= 1'b1;
          cnt <= CW'(DIV / 2 - 1);
          bitc <= 4'd0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else begin
        cnt <= CW'(DIV - 1);
        if (bitc == 4'd0) begin
          if (s2) active <= 1'b0;
          else bitc <= 4'd1;
        end else if (bitc == 4'd9) begin
          active <= 1'b0;
          if (s2) begin
            valid <= 1'b1;
            data <= sh;
          end
        end else begin
          sh <= {s2, sh[7:1]};
          bitc <= bitc + 4'd1;
        end
      end
    end
  end

  // R9: each received byte is reported for exactly one cycle
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst) valid |=> !valid);
endmodule

// File: rtl/midi_port.sv
module midi_port
  import midi_port_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000,
  parameter int BAUD   = 31250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       a0,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx_irq_en,
  input  logic       rx_irq_en,
  output logic       irq_tx,
  output logic       irq_rx,
  input  logic       midi_rx,
  output logic       midi_tx
);
  localparam int DIV = CLK_HZ / BAUD;

  logic       uart_q, uart_d;
  logic       rx_full_q, rx_full_d;
  logic [7:0] rx_data_q, rx_data_d;
  logic       ovr_q, ovr_d;
  logic       hold_vld_q, hold_vld_d;
  logic [7:0] hold_q, hold_d;
  logic       ser_busy, ser_start;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic [7:0] status;

  wire wr_cmd = cs & wr & a0;
  wire wr_dat = cs & wr & ~a0;
  wire rd_dat = cs & rd & ~a0;
  wire rd_any = cs & rd;

  assign ser_start = hold_vld_q & ~ser_busy;

  always_comb begin
    status = '0;
    status[ST_RX_N] = ~rx_full_q;
    status[ST_TX_N] = hold_vld_q;
    status[ST_OVR]  = ovr_q;
  end

  always_comb begin
    uart_d = uart_q;
    rx_full_d = rx_full_q;
    rx_data_d = rx_data_q;
    ovr_d = ovr_q;
    hold_vld_d = hold_vld_q;
    hold_d = hold_q;
    if (ser_start) hold_vld_d = 1'b0;
    if (wr_dat && uart_q && !hold_vld_q) begin
      hold_vld_d = 1'b1;
      hold_d = wdata;
    end
    if (rd_dat) rx_full_d = 1'b0;
    if (rx_valid && uart_q) begin
      if (rx_full_d) ovr_d = 1'b1;
      else begin
        rx_full_d = 1'b1;
        rx_data_d = rx_byte;
      end
    end
    if (wr_cmd) begin
      if (wdata == CMD_RESET) begin
        uart_d = 1'b0;
        hold_vld_d = 1'b0;
        ovr_d = 1'b0;
        rx_full_d = 1'b1;
        rx_data_d = ACK_BYTE;
      end else if (wdata == CMD_UART && !uart_q) begin
        uart_d = 1'b1;
        rx_full_d = 1'b1;
        rx_data_d = ACK_BYTE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uart_q <= 1'b0;
      rx_full_q <= 1'b0;
      rx_data_q <= '0;
      ovr_q <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q <= '0;
      rdata <= '0;
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      uart_q <= uart_d;
      rx_full_q <= rx_full_d;
      rx_data_q <= rx_data_d;
      ovr_q <= ovr_d;
      hold_vld_q <= hold_vld_d;
      hold_q <= hold_d;
      if (rd_any) rdata <= a0 ? status : rx_data_q;
      irq_tx <= tx_irq_en & uart_d & ~hold_vld_d;
      irq_rx <= rx_irq_en & rx_full_d;
    end
  end

  midi_tx_ser #(.DIV(DIV)) u_ser (
    .clk(clk), .rst(rst), .start(ser_start), .data(hold_q),
    .busy(ser_busy), .line(midi_tx)
  );

  midi_rx_deser #(.DIV(DIV)) u_deser (
    .clk(clk), .rst(rst), .line(midi_rx), .valid(rx_valid), .data(rx_byte)
  );

  assert_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wdata == CMD_UART && !uart_q) |=> (uart_q && rx_full_q && rx_data_q == ACK_BYTE));
  assert_noack_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wdata == CMD_UART && uart_q && !rx_full_q && !rx_valid) |=> (uart_q && !rx_full_q));
  assert_reset_cmd_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wdata == CMD_RESET) |=> (!uart_q && !hold_vld_q && !ovr_q && rx_full_q));
  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !(wr_cmd && wdata == CMD_RESET)) |=> ovr_q);
  assert_cmd_mode_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !uart_q |-> !hold_vld_q);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_irq_en && !rx_irq_en) |=> (!irq_tx && !irq_rx));
endmodule

// File: tb/midi_port_bench.sv
module midi_port_bench;
  localparam int BIT = 1_000_000 / 31250;

  logic clk = 1'b0, rst = 1'b1;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic irq_tx, irq_rx, midi_tx;
  logic midi_rx = 1'b1;

  int checks = 0, errors = 0;
  bit chk_on = 0;
  bit m_rx_full = 0;
  bit m_uart = 0;

  always #5 clk = ~clk;

  midi_port u_midi_port (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .a0(a0),
    .wdata(wdata), .rdata(rdata), .tx_irq_en(tx_en), .rx_irq_en(rx_en),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .midi_rx(midi_rx), .midi_tx(midi_tx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R8 per-clock comparison of irq_rx against the behavioural model
  always @(posedge clk) begin
    #3;
    if (chk_on) begin
      checks++;
      if (irq_rx !== (rx_en & m_rx_full)) begin
        errors++;
        $display("FAIL R8 monitor irq_rx: actual %0h expected %0h", irq_rx, rx_en & m_rx_full);
      end
    end
  end

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; a0 = sel; wdata = d;
    @(posedge clk); #1;
    if (sel) begin
      if (d == 8'hFF) begin m_uart = 0; m_rx_full = 1; end
      else if (d == 8'h3F && !m_uart) begin m_uart = 1; m_rx_full = 1; end
    end
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; a0 = sel;
    @(posedge clk); #1;
    if (!sel) m_rx_full = 0;
    @(negedge clk);
    cs = 0; rd = 0;
    d = rdata;
  endtask

  task automatic send_serial(input logic [7:0] d);
    chk_on = 0;
    @(negedge clk);
    midi_rx = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    midi_rx = 1;
    repeat (BIT) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic capture(output logic [7:0] d, output bit ok);
    int t;
    logic s0, s9;
    t = 0;
    d = '0;
    while (midi_tx !== 1'b0 && t < 20 * BIT) begin
      @(negedge clk);
      t++;
    end
    repeat (BIT / 2) @(negedge clk);
    s0 = midi_tx;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = midi_tx;
    end
    repeat (BIT) @(negedge clk);
    s9 = midi_tx;
    ok = (t < 20 * BIT) && (s0 == 1'b0) && (s9 == 1'b1);
  endtask

  task automatic expect_idle(input string tag, input int cycles);
    bit fell;
    fell = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (midi_tx !== 1'b1) fell = 1;
    end
    chk(tag, fell, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, fa, fb;
    bit oka, okb;
    tx_en = 1; rx_en = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    chk_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_tx", irq_tx, 0);
    chk("R1 irq_rx", irq_rx, 0);
    chk("R1 midi_tx", midi_tx, 1);
    rd_reg(1, v); chk("R1 status", v, 8'h80);

    // R11 command-only mode ignores data writes and serial input
    wr_reg(0, 8'h55);
    rd_reg(1, v); chk("R11 status after data write", v, 8'h80);
    expect_idle("R11 no frame in command mode", 2 * BIT);
    send_serial(8'h11);
    chk_on = 1;
    rd_reg(1, v); chk("R11 serial byte discarded", v, 8'h80);

    // R5 unknown command in command-only mode
    wr_reg(1, 8'h12);
    rd_reg(1, v); chk("R5 no ack", v, 8'h80);
    chk("R5 mode unchanged irq_tx", irq_tx, 0);

    // R2 enter UART mode
    wr_reg(1, 8'h3F);
    rd_reg(1, v); chk("R2 ack pending status", v, 8'h00);
    chk("R8 irq_tx in UART mode", irq_tx, 1);
    chk("R8 irq_rx with ack", irq_rx, 1);
    rd_reg(0, v); chk("R2 ack byte", v, 8'hFE);
    // R3 read clears, status read has no side effect
    rd_reg(1, v); chk("R3 status after read", v, 8'h80);
    rd_reg(1, v); chk("R3 repeated status read", v, 8'h80);

    // R4 second enter-UART command
    wr_reg(1, 8'h3F);
    rd_reg(1, v); chk("R4 no ack", v, 8'h80);
    chk("R4 still UART", irq_tx, 1);
    // R5 unknown command in UART mode
    wr_reg(1, 8'h12);
    rd_reg(1, v); chk("R5 no ack in UART mode", v, 8'h80);

    // R6 / R7 two outstanding bytes, third dropped
    fork
      begin
        capture(fa, oka);
        capture(fb, okb);
      end
      begin
        wr_reg(0, 8'hA5);
        repeat (3) @(negedge clk);
        wr_reg(0, 8'h3C);
        rd_reg(1, v); chk("R6 status holding full", v, 8'hC0);
        chk("R8 irq_tx low while holding full", irq_tx, 0);
        wr_reg(0, 8'h77);
      end
    join
    chk("R7 first frame framing", oka, 1);
    chk("R7 first frame data", fa, 8'hA5);
    chk("R6 second frame framing", okb, 1);
    chk("R6 second frame data", fb, 8'h3C);
    expect_idle("R6 dropped third byte", 12 * BIT);
    rd_reg(1, v); chk("R6 status after drain", v, 8'h80);
    chk("R8 irq_tx after drain", irq_tx, 1);

    // R9 receive a byte
    send_serial(8'h93);
    m_rx_full = 1; chk_on = 1;
    rd_reg(1, v); chk("R9 status rx waiting", v, 8'h00);
    chk("R8 irq_rx rx waiting", irq_rx, 1);
    rd_reg(0, v); chk("R9 rx byte", v, 8'h93);
    rd_reg(1, v); chk("R3 status after rx read", v, 8'h80);

    // R8 disabled receive request
    rx_en = 0;
    send_serial(8'h44);
    m_rx_full = 1; chk_on = 1;
    repeat (2) @(negedge clk);
    chk("R8 irq_rx disabled", irq_rx, 0);
    rx_en = 1;
    repeat (2) @(negedge clk);
    chk("R8 irq_rx re-enabled", irq_rx, 1);
    rd_reg(0, v); chk("R9 second rx byte", v, 8'h44);

    // R10 overrun
    send_serial(8'h21);
    send_serial(8'h42);
    m_rx_full = 1; chk_on = 1;
    rd_reg(1, v); chk("R10 overrun status", v, 8'h01);
    rd_reg(0, v); chk("R10 first byte kept", v, 8'h21);
    rd_reg(1, v); chk("R10 overrun sticky", v, 8'h81);

    // R12 reset command flushes and acknowledges
    fork
      begin
        capture(fa, oka);
        expect_idle("R12 flushed holding byte", 12 * BIT);
      end
      begin
        wr_reg(0, 8'hD1);
        repeat (3) @(negedge clk);
        wr_reg(0, 8'hD2);
        wr_reg(1, 8'hFF);
        rd_reg(1, v); chk("R12 status after reset cmd", v, 8'h00);
        chk("R12 left UART mode", irq_tx, 0);
        rd_reg(0, v); chk("R12 ack byte", v, 8'hFE);
      end
    join
    chk("R12 frame in flight completes", oka, 1);
    chk("R12 frame in flight data", fa, 8'hD1);
    wr_reg(0, 8'h66);
    expect_idle("R11 data ignored after reset cmd", 2 * BIT);

    chk_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule